// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table held in memory. The upper ten bits of the page number index a top-level directory whose location comes from a configured table frame. The chosen directory entry names the frame of a second-level table. The lower ten bits of the page number index that table, and its entry supplies the frame number of the page. The 12-bit byte offset is carried into the physical address without change, so pages are 4 KB.

Before any table read, the walker compares the page number with a configured table length. At each level it checks the entry's present bit and the permission bit that matches the requested access. The first failed check ends the walk. The response then carries a fault code and an all-zero address. Table entries are fetched through a read port that has at most one read in flight. A new request is taken only when the walker is idle, and each answer is reported as a single-cycle response pulse.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to address {cfg_base, 12'b0} + 4 × vaddr[31:22].
- R2: The second read goes to address {dir_entry[31:12], 12'b0} + 4 × vaddr[21:12], where dir_entry is the data returned by the first read.
- R3: When both entries pass their checks, the response has rsp_fault = 0 and rsp_paddr = {leaf_entry[31:12], vaddr[11:0]}.
- R4: If vaddr[31:12] ≥ cfg_len, the response has rsp_fault = 1, it arrives in the cycle after the request is accepted, and no table read is issued.
- R5: A directory entry with bit 0 (present) clear gives rsp_fault = 2, and no second-level read is issued.
- R6: A second-level entry with bit 0 clear gives rsp_fault = 3.
- R7: The access code req_acc is 0 for read, 1 for write, 2 for execute and 3 for reserved. Each level requires entry bit 1, 2 or 3 respectively to be set. The reserved code is never permitted. A failed check gives rsp_fault = 4, and when the failure is at the directory level no second-level read is issued.
- R8: At most one table read is in flight. mem_rd_valid and mem_rd_addr stay unchanged until mem_rd_ready is seen, no read is requested while the walker is idle, and a successful walk makes exactly two reads.
- R9: After reset, req_ready = 1, rsp_valid = 0 and mem_rd_valid = 0. req_ready is low from acceptance until the response. rsp_valid is high for exactly one cycle. rsp_paddr is zero whenever rsp_fault is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 20 | Frame number of the top-level directory |
| cfg_len | input | 21 | Number of valid pages; page numbers at or above it fault |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 3 | 0 none, 1 length, 2 directory absent, 3 leaf absent, 4 permission |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid, in a cycle after the read was accepted |
| mem_rsp_data | input | 32 | Table entry |

## Verification
The bench steers walks through every exit of the walk: full success with each of the three access codes, a leaf that is absent, a directory that is absent, and permission refusals at the directory level and at the leaf level. The refusals are told apart by the fault code and by the number of reads issued. Page numbers just below and exactly at the length bound, the all-ones address, a zero length and the largest length show whether the bound is compared before any read and with the right inequality. A nonzero directory frame and the last index of a second-level table expose any fault in how the entry addresses are formed. The memory model stalls its ready and varies its latency, which checks that the read request is held stable and that a response is taken only after the read it answers.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  // entry flag bit positions (entry bits 3:0)
  localparam int unsigned ENT_PRESENT = 0;
  localparam int unsigned ENT_RD      = 1;
  localparam int unsigned ENT_WR      = 2;
  localparam int unsigned ENT_EX      = 3;
  localparam int unsigned ENT_FLAGS_W = 4;

  // byte shift of one 4-byte table entry
  localparam int unsigned ENT_SHIFT   = 2;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_LEN   = 3'd1,
    FLT_OUTER = 3'd2,
    FLT_INNER = 3'd3,
    FLT_PERM  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OUTER,
    ST_INNER,
    ST_RESP
  } walk_st_e;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int unsigned FRM_W = 20,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic [FRM_W-1:0]       tbl_frame,
  input  logic [IDX_W-1:0]       idx,
  output logic [FRM_W+OFF_W-1:0] ent_addr
);
  import pt_walk_pkg::*;

  localparam int unsigned PAD_W = OFF_W - IDX_W - ENT_SHIFT;

  // The table is frame aligned and idx*4 fits inside the offset field,
  // so the sum reduces to a concatenation with no carry chain.
  generate
    if (PAD_W > 0) begin : g_pad
      assign ent_addr = {tbl_frame, {PAD_W{1'b0}}, idx, {ENT_SHIFT{1'b0}}};
    end else begin : g_nopad
      assign ent_addr = {tbl_frame, idx, {ENT_SHIFT{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/pt_pte_check.sv
module pt_pte_check
  import pt_walk_pkg::*;
(
  input  logic [ENT_FLAGS_W-1:0] flags,
  input  acc_e                   acc,
  output logic                   present,
  output logic                   allowed
);

  assign present = flags[ENT_PRESENT];

  always_comb begin
    unique case (acc)
      ACC_RD:  allowed = flags[ENT_RD];
      ACC_WR:  allowed = flags[ENT_WR];
      ACC_EX:  allowed = flags[ENT_EX];
      default: allowed = 1'b0;
    endcase
  end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned FRM_W = 20,
  localparam int unsigned VPN_W = 2 * IDX_W,
  localparam int unsigned VA_W  = VPN_W + OFF_W,
  localparam int unsigned PA_W  = FRM_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W:0]   cfg_len,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  output logic [VA_W-1:0]  vaddr_q,
  output acc_e             acc_q,
  input  logic [PA_W-1:0]  outer_addr,
  input  logic [PA_W-1:0]  inner_addr,
  input  logic             ent_present,
  input  logic             ent_allowed,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_fault,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [FRM_W-1:0] mem_rsp_frame
);

  walk_st_e        state_q;
  logic            rd_valid_q;
  logic [PA_W-1:0] rd_addr_q;
  logic            rsp_valid_q;
  logic [PA_W-1:0] rsp_paddr_q;
  fault_e          rsp_fault_q;

  logic [VPN_W-1:0] req_vpn;
  logic             len_bad;
  logic             rsp_take;

  assign req_vpn  = req_vaddr[VA_W-1:OFF_W];
  assign len_bad  = ({1'b0, req_vpn} >= cfg_len);
  // data counts only once the read it answers has left the port
  assign rsp_take = mem_rsp_valid && !rd_valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      vaddr_q     <= '0;
      acc_q       <= ACC_RD;
      rd_valid_q  <= 1'b0;
      rd_addr_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_fault_q <= FLT_NONE;
    end else begin
      rsp_valid_q <= 1'b0;
      if (rd_valid_q && mem_rd_ready) begin
        rd_valid_q <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            acc_q   <= acc_e'(req_acc);
            if (len_bad) begin
              rsp_valid_q <= 1'b1;
              rsp_paddr_q <= '0;
              rsp_fault_q <= FLT_LEN;
              state_q     <= ST_RESP;
            end else begin
              rd_valid_q <= 1'b1;
              rd_addr_q  <= outer_addr;
              state_q    <= ST_OUTER;
            end
          end
        end
        ST_OUTER: begin
          if (rsp_take) begin
            if (!ent_present || !ent_allowed) begin
              rsp_valid_q <= 1'b1;
              rsp_paddr_q <= '0;
              rsp_fault_q <= ent_present ? FLT_PERM : FLT_OUTER;
              state_q     <= ST_RESP;
            end else begin
              rd_valid_q <= 1'b1;
              rd_addr_q  <= inner_addr;
              state_q    <= ST_INNER;
            end
          end
        end
        ST_INNER: begin
          if (rsp_take) begin
            rsp_valid_q <= 1'b1;
            state_q     <= ST_RESP;
            if (!ent_present || !ent_allowed) begin
              rsp_paddr_q <= '0;
              rsp_fault_q <= ent_present ? FLT_PERM : FLT_INNER;
            end else begin
              rsp_paddr_q <= {mem_rsp_frame, vaddr_q[OFF_W-1:0]};
              rsp_fault_q <= FLT_NONE;
            end
          end
        end
        ST_RESP: begin
          state_q <= ST_IDLE;
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign rsp_valid    = rsp_valid_q;
  assign rsp_paddr    = rsp_paddr_q;
  assign rsp_fault    = rsp_fault_q;
  assign mem_rd_valid = rd_valid_q;
  assign mem_rd_addr  = rd_addr_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned FRM_W = 20,
  localparam int unsigned VPN_W = 2 * IDX_W,
  localparam int unsigned VA_W  = VPN_W + OFF_W,
  localparam int unsigned PA_W  = FRM_W + OFF_W,
  localparam int unsigned ENT_W = FRM_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FRM_W-1:0] cfg_base,
  input  logic [VPN_W:0]   cfg_len,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_fault,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data
);

  logic [VA_W-1:0]  vaddr_q;
  acc_e             acc_q;
  logic [PA_W-1:0]  outer_addr;
  logic [PA_W-1:0]  inner_addr;
  logic [FRM_W-1:0] ent_frame;
  logic             ent_present;
  logic             ent_allowed;
  logic             unused_rsv;

  assign ent_frame  = mem_rsp_data[ENT_W-1:OFF_W];
  assign unused_rsv = ^mem_rsp_data[OFF_W-1:ENT_FLAGS_W];

  // directory entry address, from the incoming request
  pt_entry_addr #(.FRM_W(FRM_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_outer_addr (
    .tbl_frame (cfg_base),
    .idx       (req_vaddr[VA_W-1:VA_W-IDX_W]),
    .ent_addr  (outer_addr)
  );

  // second-level entry address, from the returned directory entry
  pt_entry_addr #(.FRM_W(FRM_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_inner_addr (
    .tbl_frame (ent_frame),
    .idx       (vaddr_q[OFF_W+IDX_W-1:OFF_W]),
    .ent_addr  (inner_addr)
  );

  pt_pte_check u_check (
    .flags   (mem_rsp_data[ENT_FLAGS_W-1:0]),
    .acc     (acc_q),
    .present (ent_present),
    .allowed (ent_allowed)
  );

  pt_walk_ctrl #(.IDX_W(IDX_W), .OFF_W(OFF_W), .FRM_W(FRM_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .cfg_len       (cfg_len),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_acc       (req_acc),
    .vaddr_q       (vaddr_q),
    .acc_q         (acc_q),
    .outer_addr    (outer_addr),
    .inner_addr    (inner_addr),
    .ent_present   (ent_present),
    .ent_allowed   (ent_allowed),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_frame (ent_frame)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned FRM_W = 20,
  localparam int unsigned VPN_W = 2 * IDX_W,
  localparam int unsigned VA_W  = VPN_W + OFF_W,
  localparam int unsigned PA_W  = FRM_W + OFF_W
) (
  input logic            clk,
  input logic            rst,
  input logic [VPN_W:0]  cfg_len,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [2:0]      rsp_fault,
  input logic            mem_rd_valid,
  input logic            mem_rd_ready,
  input logic [PA_W-1:0] mem_rd_addr
);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R8
  idle_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && mem_rd_valid));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  rsp_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R9
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0));

  // R4
  len_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && ({1'b0, req_vaddr[VA_W-1:OFF_W]} >= cfg_len))
      |=> (rsp_valid && rsp_fault == 3'd1 && !mem_rd_valid));

endmodule

bind pt_walker pt_walker_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W), .FRM_W(FRM_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_len      (cfg_len),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_vaddr    (req_vaddr),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] cfg_base = '0;
  logic [20:0] cfg_len = 21'h000C00;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk (clk), .rst (rst), .cfg_base (cfg_base), .cfg_len (cfg_len),
    .req_valid (req_valid), .req_ready (req_ready), .req_vaddr (req_vaddr),
    .req_acc (req_acc), .rsp_valid (rsp_valid), .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault), .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready), .mem_rd_addr (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data)
  );

  int errors = 0;
  int checks = 0;

  logic [31:0] mem [4096];
  int          rd_cnt = 0;
  logic [31:0] rd_log [2];

  // vaddr, acc, fault, paddr, reads  (base 0, len 0xC00)
  localparam int NV = 15;
  localparam logic [70:0] VECS [NV] = '{
    {32'h00000ABC, 2'd0, 3'd0, 32'h12345ABC, 2'd2},
    {32'h00001123, 2'd1, 3'd4, 32'h00000000, 2'd2},
    {32'h00001FFF, 2'd0, 3'd0, 32'hABCDEFFF, 2'd2},
    {32'h00002000, 2'd0, 3'd3, 32'h00000000, 2'd2},
    {32'h00005010, 2'd2, 3'd0, 32'h00077010, 2'd2},
    {32'h00005010, 2'd0, 3'd4, 32'h00000000, 2'd2},
    {32'h003FF000, 2'd1, 3'd0, 32'hFFFFF000, 2'd2},
    {32'h003FF001, 2'd2, 3'd4, 32'h00000000, 2'd2},
    {32'h00404777, 2'd0, 3'd0, 32'h0BEEF777, 2'd2},
    {32'h00404777, 2'd1, 3'd4, 32'h00000000, 2'd1},
    {32'h00403000, 2'd0, 3'd3, 32'h00000000, 2'd2},
    {32'h00800000, 2'd0, 3'd2, 32'h00000000, 2'd1},
    {32'h00C00000, 2'd0, 3'd1, 32'h00000000, 2'd0},
    {32'hFFFFFFFF, 2'd0, 3'd1, 32'h00000000, 2'd0},
    {32'h00BFF000, 2'd0, 3'd2, 32'h00000000, 2'd1}
  };

  function automatic string fault_req(input logic [2:0] f);
    case (f)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic perm_ok(input logic [31:0] e, input logic [1:0] acc);
    case (acc)
      2'd0: return e[1];
      2'd1: return e[2];
      2'd2: return e[3];
      default: return 1'b0;
    endcase
  endfunction

  // reference walk derived from R1..R7
  task automatic ref_walk(input logic [31:0] va, input logic [1:0] acc,
                          output logic [2:0] f, output logic [31:0] pa,
                          output int nrd, output logic [31:0] a1,
                          output logic [31:0] a2);
    logic [31:0] e1, e2;
    f = 3'd0; pa = '0; nrd = 0;
    a1 = {cfg_base, 12'h000} + {20'h0, va[31:22], 2'b00};
    a2 = '0;
    if ({1'b0, va[31:12]} >= cfg_len) begin
      f = 3'd1;
      return;
    end
    e1 = mem[a1[13:2]]; nrd = 1;
    if (!e1[0]) begin f = 3'd2; return; end
    if (!perm_ok(e1, acc)) begin f = 3'd4; return; end
    a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    e2 = mem[a2[13:2]]; nrd = 2;
    if (!e2[0]) begin f = 3'd3; return; end
    if (!perm_ok(e2, acc)) begin f = 3'd4; return; end
    pa = {e2[31:12], va[11:0]};
  endtask

  // memory responder: stalls ready, latency 0..1 extra cycles
  initial begin
    int tick = 0;
    logic pend = 1'b0;
    int lat = 0;
    logic [31:0] paddr_q = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[paddr_q[13:2]];
          pend = 1'b0;
        end else begin
          lat--;
        end
      end
      tick++;
      mem_rd_ready = (tick % 3) != 0;
      if (mem_rd_valid && mem_rd_ready && !pend && !rst) begin
        pend = 1'b1;
        lat = tick % 2;
        paddr_q = mem_rd_addr;
        if (rd_cnt < 2) rd_log[rd_cnt] = mem_rd_addr;
        rd_cnt++;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                      output logic [2:0] f, output logic [31:0] pa,
                      output int nrd, output logic busy_ok, output logic pulse_ok);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0;
    req_vaddr = va; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1'b1;
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    if (req_ready) busy_ok = 1'b0;
    f = rsp_fault; pa = rsp_paddr; nrd = rd_cnt;
    @(negedge clk);
    pulse_ok = !rsp_valid;
  endtask

  task automatic run(input logic [31:0] va, input logic [1:0] acc,
                     input logic [2:0] ef, input logic [31:0] epa, input int enrd);
    logic [2:0] f, rf; logic [31:0] pa, rpa, a1, a2; int nrd, rnrd;
    logic busy_ok, pulse_ok;
    ref_walk(va, acc, rf, rpa, rnrd, a1, a2);
    walk(va, acc, f, pa, nrd, busy_ok, pulse_ok);
    chk(fault_req(ef), "fault code", {29'h0, f}, {29'h0, ef});
    chk("R3", "paddr", pa, epa);
    chk("R8", "read count", nrd, enrd);
    if (enrd >= 1) chk("R1", "directory entry address", rd_log[0], a1);
    if (enrd >= 2) chk("R2", "leaf entry address", rd_log[1], a2);
    chk("R9", "ready low while busy", {31'h0, busy_ok}, 32'h1);
    chk("R9", "single-cycle response", {31'h0, pulse_ok}, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'h000] = 32'h0000100F;
    mem[12'h001] = 32'h00002003;
    mem[12'h002] = 32'h00003002;
    mem[12'h400] = 32'h1234500F;
    mem[12'h401] = 32'hABCDE003;
    mem[12'h402] = 32'h5555500E;
    mem[12'h405] = 32'h00077009;
    mem[12'h7FF] = 32'hFFFFF007;
    mem[12'h804] = 32'h0BEEF00F;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0] rf; logic [31:0] rpa, a1, a2; int rnrd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9", "req_ready after reset", {31'h0, req_ready}, 32'h1);
    chk("R9", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk("R9", "mem_rd_valid after reset", {31'h0, mem_rd_valid}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      run(VECS[v][70:39], VECS[v][38:37], VECS[v][36:34], VECS[v][33:2],
          int'(VECS[v][1:0]));
    end

    // R7 reserved access code refused at the directory
    run(32'h00000ABC, 2'd3, 3'd4, 32'h0, 1);

    // R4 zero length: every page out of range
    cfg_len = 21'h0;
    run(32'h00000000, 2'd0, 3'd1, 32'h0, 0);

    // R5 largest length lets the top page through to an absent directory slot
    cfg_len = 21'h100000;
    run(32'hFFFFFFFF, 2'd0, 3'd2, 32'h0, 1);

    // R1 nonzero directory frame
    cfg_base = 20'h00001;
    ref_walk(32'h00000123, 2'd0, rf, rpa, rnrd, a1, a2);
    run(32'h00000123, 2'd0, rf, rpa, rnrd);
    chk("R1", "relocated directory reads word 0x1000", a1, 32'h00001000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule